// File: doc/BRIEF.md
# Half-Rate DDR Write Command Scheduler

This block sits on the controller side of a half-rate DDR SDRAM controller-to-PHY interface. One controller clock covers two memory-clock command slots. For each accepted write request it opens the row with an activate command, issues the column write a fixed number of controller clocks later, and then presents two controller clocks of write data to the PHY. Both commands are placed in the first slot of the two-slot word.

The run-time write latency comes from calibration. It sets how many controller clocks pass between the clock that carries the write chip select and the first clock of valid data. The strobe-burst enable flag leads the data-valid flag by one memory-clock slot, which is half a controller clock. The block takes one request at a time and holds its ready output low until the data window of the current burst has closed.

Top module: `hr_wr_sched`

## Requirements
- R1: Every command and strobe output is two bits wide. Bit 0 is the earlier (even) memory-clock slot and bit 1 is the later (odd) slot. Chip select is driven low only in bit 0, so `cmd_cs_n[1]` stays high at all times.
- R2: Commands are active-low. Activate is ras_n=0, cas_n=1, we_n=1. Write is ras_n=1, cas_n=0, we_n=0. On an idle slot chip select and all three strobes are 1. `cmd_addr` carries the row during activate, the column during write, and zero otherwise.
- R3: Activate appears in the controller clock after the clock in which a request is accepted (req_valid and req_ready high at a clock edge). Write appears exactly TRCD controller clocks after activate.
- R4: `wdata_valid` is 2'b11 for exactly two consecutive controller clocks. The first of them is N clocks after the write-command clock, where N is `wlat` as sampled at acceptance.
- R5: A sampled `wlat` of 0 is treated as 1.
- R6: `dqs_burst` is 2'b10 in the clock before the first valid clock, 2'b11 in the first valid clock and 2'b01 in the second. It is 2'b00 at all other times, so it rises and falls one slot ahead of data valid.
- R7: The first valid clock carries `req_data[DW-1:0]` and the second carries `req_data[2*DW-1:DW]`. `wdata` is zero whenever data is not valid.
- R8: `req_ready` is high only when no burst is pending. It returns high in the clock after the second valid clock. Request fields presented while it is low are ignored.
- R9: A change of `wlat` after acceptance does not change the timing of the current burst.
- R10: A synchronous active-low reset, applied at any time, forces `cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` to 2'b11, forces `dqs_burst`, `wdata_valid` and `wdata` to zero, and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_row | input | AW | Row address for activate |
| req_col | input | AW | Column address for write |
| req_data | input | 2*DW | Burst data; the low half is sent first |
| wlat | input | WLW | Calibrated write latency in controller clocks |
| cmd_cs_n | output | 2 | Per-slot chip select, active low |
| cmd_ras_n | output | 2 | Per-slot RAS, active low |
| cmd_cas_n | output | 2 | Per-slot CAS, active low |
| cmd_we_n | output | 2 | Per-slot write enable, active low |
| cmd_addr | output | AW | Address for the command in the lead slot |
| dqs_burst | output | 2 | Per-slot strobe-burst enable |
| wdata_valid | output | 2 | Per-slot write-data valid |
| wdata | output | DW | Write data beat |

## Verification
The hardest case to reach is a latency of one. There the burst flag has to rise in the odd slot of the same clock that carries the write command, and no clock separates the command from the data. The stimulus table reaches this case in two ways: directly with a latency of 1, and through the zero-latency substitution. A maximum latency of 15 tests the other end of the counter. Directed runs change `wlat` in the middle of a burst and keep `req_valid` high with other data while ready is low. A further run applies reset in the middle of a burst and then sends a fresh burst to show that the sequence restarts cleanly.

// File: rtl/hr_wr_pkg.sv
// Package: shared types for the half-rate write command scheduler.
// Assumes two memory-clock slots per controller clock, with commands placed in slot 0.
package hr_wr_pkg;
    localparam int NSLOT     = 2;   // memory-clock slots per controller clock
    localparam int LEAD_SLOT = 0;   // slot that carries commands

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACT   = 3'd1,
        ST_GAP   = 3'd2,
        ST_WR    = 3'd3,
        ST_LAT   = 3'd4,
        ST_DATA0 = 3'd5,
        ST_DATA1 = 3'd6
    } st_e;
endpackage

// File: rtl/hr_lat_timer.sv
// Module: loadable down-counter shared by the activate-to-write gap and the write latency.
// Assumes a load value of zero is never used to wait (the caller bypasses the wait instead).
module hr_lat_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          at_one
);
    logic [TW-1:0] cnt_q;

    // Load the count, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Flag the last wait cycle.
    always_comb at_one = (cnt_q == TW'(1));
endmodule

// File: rtl/hr_slot_cmd_enc.sv
// Module: turns a command kind into per-slot active-low strobes and a command address.
// Assumes only the lead slot ever carries a command; every other slot stays idle.
module hr_slot_cmd_enc
    import hr_wr_pkg::*;
#(
    parameter int AW = 14
) (
    input  cmd_e            cmd,
    input  logic [AW-1:0]   row,
    input  logic [AW-1:0]   col,
    output logic [NSLOT-1:0] cs_n,
    output logic [NSLOT-1:0] ras_n,
    output logic [NSLOT-1:0] cas_n,
    output logic [NSLOT-1:0] we_n,
    output logic [AW-1:0]   addr
);
    logic lead_cs_n, lead_ras_n, lead_cas_n, lead_we_n;

    // Decode the lead-slot strobe levels from the command kind.
    always_comb begin
        lead_cs_n  = (cmd == CMD_NOP);
        lead_ras_n = (cmd != CMD_ACT);
        lead_cas_n = (cmd != CMD_WR);
        lead_we_n  = (cmd != CMD_WR);
    end

    // Choose the address that goes with the command.
    always_comb begin
        case (cmd)
            CMD_ACT: addr = row;
            CMD_WR:  addr = col;
            default: addr = '0;
        endcase
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s == LEAD_SLOT) begin : g_lead
            assign cs_n[s]  = lead_cs_n;
            assign ras_n[s] = lead_ras_n;
            assign cas_n[s] = lead_cas_n;
            assign we_n[s]  = lead_we_n;
        end else begin : g_idle
            assign cs_n[s]  = 1'b1;
            assign ras_n[s] = 1'b1;
            assign cas_n[s] = 1'b1;
            assign we_n[s]  = 1'b1;
        end
    end
endmodule

// File: rtl/hr_wdata_stage.sv
// Module: holds one burst of write data and presents it one beat per controller clock.
// Assumes beat 0 sits in the lowest DW bits of the captured word.
module hr_wdata_stage #(
    parameter int DW    = 32,
    parameter int BEATS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [BEATS*DW-1:0] cap_data,
    input  logic               beat_en,
    input  logic [$clog2(BEATS)-1:0] beat_sel,
    output logic [DW-1:0]      wdata
);
    logic [DW-1:0] beat_q [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        // Capture one beat of the request word on acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n)
                beat_q[b] <= '0;
            else if (capture)
                beat_q[b] <= cap_data[b*DW +: DW];
        end
    end

    // Drive the selected beat, or zero when data is not valid.
    always_comb wdata = beat_en ? beat_q[beat_sel] : '0;
endmodule

// File: rtl/hr_wr_sched.sv
// Module: top of the half-rate write command scheduler.
// It sequences activate, write and two data clocks, with the data timed by a latency sampled when the request is accepted.
// Assumes TRCD >= 1 and one outstanding request at a time.
module hr_wr_sched
    import hr_wr_pkg::*;
#(
    parameter int AW   = 14,
    parameter int DW   = 32,
    parameter int WLW  = 4,
    parameter int TRCD = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_row,
    input  logic [AW-1:0]   req_col,
    input  logic [2*DW-1:0] req_data,
    input  logic [WLW-1:0]  wlat,
    output logic [1:0]      cmd_cs_n,
    output logic [1:0]      cmd_ras_n,
    output logic [1:0]      cmd_cas_n,
    output logic [1:0]      cmd_we_n,
    output logic [AW-1:0]   cmd_addr,
    output logic [1:0]      dqs_burst,
    output logic [1:0]      wdata_valid,
    output logic [DW-1:0]   wdata
);
    localparam int TCW = $clog2(TRCD + 1);
    localparam int TW  = (WLW > TCW) ? WLW : TCW;

    st_e            st_q, st_d;
    logic [WLW-1:0] lat_q;
    logic [AW-1:0]  row_q, col_q;
    logic           accept, tmr_load, tmr_one, pre_burst, in_data;
    logic [TW-1:0]  tmr_val;
    cmd_e           cmd;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Hold the address and effective latency of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= WLW'(1);
            row_q <= '0;
            col_q <= '0;
        end else if (accept) begin
            lat_q <= (wlat == '0) ? WLW'(1) : wlat;
            row_q <= req_row;
            col_q <= req_col;
        end
    end

    // Load the gap count on activate and the latency count on write.
    always_comb begin
        tmr_load = (st_q == ST_ACT) || (st_q == ST_WR);
        tmr_val  = (st_q == ST_ACT) ? TW'(TRCD - 1) : TW'(lat_q - 1'b1);
    end

    hr_lat_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .at_one   (tmr_one)
    );

    // Next-state sequencing of one write burst.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (accept) st_d = ST_ACT;
            ST_ACT:   st_d = (TRCD == 1) ? ST_WR : ST_GAP;
            ST_GAP:   if (tmr_one) st_d = ST_WR;
            ST_WR:    st_d = (lat_q == WLW'(1)) ? ST_DATA0 : ST_LAT;
            ST_LAT:   if (tmr_one) st_d = ST_DATA0;
            ST_DATA0: st_d = ST_DATA1;
            ST_DATA1: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Command kind for the lead slot of this clock.
    always_comb begin
        case (st_q)
            ST_ACT:  cmd = CMD_ACT;
            ST_WR:   cmd = CMD_WR;
            default: cmd = CMD_NOP;
        endcase
    end

    hr_slot_cmd_enc #(.AW(AW)) u_enc (
        .cmd   (cmd),
        .row   (row_q),
        .col   (col_q),
        .cs_n  (cmd_cs_n),
        .ras_n (cmd_ras_n),
        .cas_n (cmd_cas_n),
        .we_n  (cmd_we_n),
        .addr  (cmd_addr)
    );

    // Strobe-burst and data-valid flags, with the burst flag one slot ahead.
    always_comb begin
        in_data     = (st_q == ST_DATA0) || (st_q == ST_DATA1);
        pre_burst   = ((st_q == ST_WR) && (lat_q == WLW'(1))) ||
                      ((st_q == ST_LAT) && tmr_one);
        wdata_valid = {2{in_data}};
        dqs_burst   = {pre_burst || (st_q == ST_DATA0), in_data};
    end

    hr_wdata_stage #(.DW(DW), .BEATS(2)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .cap_data (req_data),
        .beat_en  (in_data),
        .beat_sel (st_q == ST_DATA1),
        .wdata    (wdata)
    );
endmodule

// File: rtl/hr_wr_sched_chk.sv
// Checker: temporal properties of the write scheduler, attached by bind.
// Assumes synchronous active-low reset; the latency is tracked with counters here.
module hr_wr_sched_chk #(
    parameter int WLW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [WLW-1:0] wlat,
    input logic [1:0]     cmd_cs_n,
    input logic [1:0]     cmd_ras_n,
    input logic [1:0]     cmd_cas_n,
    input logic [1:0]     cmd_we_n,
    input logic [1:0]     dqs_burst,
    input logic [1:0]     wdata_valid
);
    logic [WLW-1:0] lat_cap;
    logic [WLW:0]   since_wr;
    logic           wr_seen;

    assign wr_seen = !cmd_cs_n[0] && !cmd_cas_n[0];

    // Record the effective latency at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_cap <= WLW'(1);
        else if (req_valid && req_ready)
            lat_cap <= (wlat == '0) ? WLW'(1) : wlat;
    end

    // Count clocks since the write command, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_wr <= '0;
        else if (wr_seen)
            since_wr <= (WLW+1)'(1);
        else if (since_wr != '0 && since_wr != '1)
            since_wr <= since_wr + 1'b1;
    end

    assert_cs_lead_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs_n[1] == 1'b1);

    assert_cmd_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cs_n[0] |-> ((!cmd_ras_n[0] && cmd_cas_n[0] && cmd_we_n[0]) ||
                          (cmd_ras_n[0] && !cmd_cas_n[0] && !cmd_we_n[0])));

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs_n[0] |-> (cmd_ras_n == 2'b11 && cmd_cas_n == 2'b11 && cmd_we_n == 2'b11));

    assert_valid_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdata_valid[0]) |=> wdata_valid == 2'b11);

    assert_valid_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wdata_valid, 2) == 2'b11 && $past(wdata_valid) == 2'b11) |-> wdata_valid == 2'b00);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdata_valid[0]) |-> since_wr == {1'b0, lat_cap});

    assert_burst_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdata_valid[0]) |-> $past(dqs_burst) == 2'b10);

    assert_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_valid != 2'b00 || !cmd_cs_n[0]) |-> !req_ready);

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (cmd_cs_n == 2'b11 && dqs_burst == 2'b00 && wdata_valid == 2'b00));
endmodule

bind hr_wr_sched hr_wr_sched_chk #(.WLW(WLW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .wlat        (wlat),
    .cmd_cs_n    (cmd_cs_n),
    .cmd_ras_n   (cmd_ras_n),
    .cmd_cas_n   (cmd_cas_n),
    .cmd_we_n    (cmd_we_n),
    .dqs_burst   (dqs_burst),
    .wdata_valid (wdata_valid)
);

// File: tb/hr_wr_sched_bench.sv
module hr_wr_sched_bench;
    localparam int AW = 14, DW = 32, WLW = 4, TRCD = 3;
    localparam int NV = 6;
    localparam logic [WLW-1:0]  V_LAT [NV] = '{4'd2, 4'd1, 4'd5, 4'd0, 4'd15, 4'd3};
    localparam logic [AW-1:0]   V_ROW [NV] = '{14'h0020, 14'h3fff, 14'h0001, 14'h1234, 14'h2aaa, 14'h0000};
    localparam logic [AW-1:0]   V_COL [NV] = '{14'h0008, 14'h0000, 14'h3ffe, 14'h0155, 14'h1555, 14'h0040};
    localparam logic [2*DW-1:0] V_DAT [NV] = '{64'h07060504_03020100, 64'hffffffff_00000000,
                                              64'h0f0e0d0c_0b0a0908, 64'hdeadbeef_cafef00d,
                                              64'h12345678_9abcdef0, 64'h00000001_80000000};

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_row = '0, req_col = '0, cmd_addr;
    logic [2*DW-1:0] req_data = '0;
    logic [WLW-1:0] wlat = 4'd2;
    logic [1:0] cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, dqs_burst, wdata_valid;
    logic [DW-1:0] wdata;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    hr_wr_sched #(.AW(AW), .DW(DW), .WLW(WLW), .TRCD(TRCD)) u_hr_wr_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_data(req_data), .wlat(wlat),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr), .dqs_burst(dqs_burst),
        .wdata_valid(wdata_valid), .wdata(wdata));

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cyc);
            finish_run();
        end
    end

    function automatic logic [120:0] observed();
        return {req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_addr, dqs_burst, wdata_valid, wdata, 32'h0, 12'h0};
    endfunction

    task automatic check(input string tag, input logic [120:0] exp);
        logic [120:0] act = observed();
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [120:0] idle_vec(input logic rdy);
        return {rdy, 2'b11, 2'b11, 2'b11, 2'b11, {AW{1'b0}}, 2'b00, 2'b00, {DW{1'b0}}, 32'h0, 12'h0};
    endfunction

    // Expected outputs c clocks after acceptance (R1, R2, R3, R4, R6, R7, R8).
    function automatic logic [120:0] exp_vec(input int c, input int n, input logic [AW-1:0] row,
                                             input logic [AW-1:0] col, input logic [2*DW-1:0] dat);
        logic [1:0] cs = 2'b11, ras = 2'b11, cas = 2'b11, we = 2'b11, bst = 2'b00, vld = 2'b00;
        logic [AW-1:0] ad = '0;
        logic [DW-1:0] wd = '0;
        if (c == 1) begin cs = 2'b10; ras = 2'b10; ad = row; end
        if (c == 1 + TRCD) begin cs = 2'b10; cas = 2'b10; we = 2'b10; ad = col; end
        if (c == TRCD + n) bst = 2'b10;
        if (c == 1 + TRCD + n) begin bst = 2'b11; vld = 2'b11; wd = dat[DW-1:0]; end
        if (c == 2 + TRCD + n) begin bst = 2'b01; vld = 2'b11; wd = dat[2*DW-1:DW]; end
        return {(c >= 3 + TRCD + n), cs, ras, cas, we, ad, bst, vld, wd, 32'h0, 12'h0};
    endfunction

    // mode 0: plain; 1: change wlat after accept (R9); 2: keep req_valid with other data (R8)
    task automatic run_burst(input logic [WLW-1:0] lat, input logic [AW-1:0] row,
                             input logic [AW-1:0] col, input logic [2*DW-1:0] dat, input int mode);
        int n = (lat == 0) ? 1 : int'(lat);
        @(negedge clk);
        req_valid = 1'b1; wlat = lat; req_row = row; req_col = col; req_data = dat;
        @(posedge clk);
        for (int c = 1; c <= 3 + TRCD + n; c++) begin
            @(negedge clk);
            check($sformatf("R3/R4/R5/R6/R7/R8 lat=%0d c=%0d mode=%0d", lat, c, mode),
                  exp_vec(c, n, row, col, dat));
            if (c == 1) begin
                req_valid = (mode == 2);
                if (mode == 1) wlat = lat + 4'd3;      // R9
                if (mode == 2) begin req_data = ~dat; req_row = ~row; req_col = ~col; end
            end
            if (c == 3 + TRCD + n) req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset state", idle_vec(1'b1));
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", idle_vec(1'b1));

        for (int i = 0; i < NV; i++) run_burst(V_LAT[i], V_ROW[i], V_COL[i], V_DAT[i], 0);

        run_burst(4'd2, 14'h0abc, 14'h0def, 64'h11112222_33334444, 1);  // R9
        run_burst(4'd3, 14'h0111, 14'h0222, 64'h55556666_77778888, 2);  // R8

        // R10: reset in the middle of a burst
        @(negedge clk);
        req_valid = 1'b1; wlat = 4'd4; req_row = 14'h0bad; req_data = 64'hffff0000_ffff0000;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        repeat (TRCD + 3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset mid-burst", idle_vec(1'b1));
        rst_n = 1'b1;
        run_burst(4'd1, 14'h0007, 14'h0009, 64'h0000aaaa_bbbb0000, 0);   // R1 R2 after reset

        @(negedge clk);
        check("R8 ready idle at end", idle_vec(1'b1));
        finish_run();
    end
endmodule